// File: doc/BRIEF.md
# Floating-Point Issue Timing Controller

This block decides when a floating-point operation may leave the issue stage and enter its execution pipe. It models only timing: each operation carries a 3-bit opcode and a destination tag. The opcode selects one of six pipes, and each pipe has a fixed latency and a fixed minimum spacing between two accepted operations. The controller tracks every accepted operation in a small pool of in-flight entries. Each entry counts down the remaining latency. When an entry expires, the controller drives a one-cycle completion strobe with the entry's tag.

The issue side is a valid/ready stream. The producer raises `in_valid` with `in_op` and `in_tag`. The operation is taken on a clock edge where both `in_valid` and `in_ready` are high. While `in_ready` is low, the producer must keep the offer and its fields unchanged. A held offer is never discarded.

`in_ready` drops in three cases:
- the selected pipe is still inside its spacing window;
- every in-flight entry is occupied;
- the offered result would reach the single completion port on the same cycle as a result already in flight.

In the third case, `wb_conflict` is also raised, and the offer waits at least one cycle. The completion side has no back-pressure. Results from short pipes may retire before results from longer pipes that were issued earlier.

Top module: `fpi_issue_ctrl`

## Requirements
- R1: After reset, `done_valid` and `wb_conflict` are low, and `in_ready` is high for any offered opcode.
- R2: Latency by opcode:
  - 0 add and 1 subtract: 4 cycles.
  - 2 multiply: 8 cycles.
  - 3 divide: 36 cycles.
  - 4 square root: 112 cycles.
  - 5 negate and 6 absolute value: 2 cycles.
  - 7 compare: 3 cycles.

  An operation accepted on clock edge e produces `done_valid` high, with its tag on `done_tag`, for the single cycle that follows edge e+L, where L is its latency.
- R3: Pipes and their minimum spacing between accepted operations:
  - {add, subtract}: 3.
  - multiply: 4.
  - divide: 35.
  - square root: 111.
  - {negate, absolute value}: 1.
  - compare: 2.

  After an acceptance on edge e, an operation for the same pipe is refused until edge e+I, where I is that pipe's spacing.
- R4: A refused offer is held by the producer and is accepted later. Every accepted tag completes exactly once.
- R5: Completion follows latency, not program order. A short operation issued after a long one retires first.
- R6: If an offered operation would complete on the same cycle as an in-flight one, `wb_conflict` is high and `in_ready` is low for that cycle.
- R7: When all `NSLOTS` in-flight entries are occupied, `in_ready` is low.
- R8: At most one completion is presented per cycle.
- R9: A pipe inside its spacing window does not block an offer to a different, idle pipe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Offer will be taken on this edge |
| in_op | input | 3 | Opcode, encoding as in R2 |
| in_tag | input | TAG_W | Destination tag |
| done_valid | output | 1 | One-cycle completion strobe |
| done_tag | output | TAG_W | Tag of the completing operation |
| wb_conflict | output | 1 | Offer held back by a completion-port collision |

## Verification
Errors in internal state show up at the ports in the following ways:
- **Wrong countdown value.** The completion strobe moves off the cycle the bench computes. This appears exactly L cycles after acceptance.
- **Spacing counter off by one.** `in_ready` rises one edge early or late on the next same-pipe offer.
- **Entry leaked or freed twice.** A tag is either missing at drain or arrives twice.
- **Missed collision.** Two expected completions fall on one cycle, which the bench flags on that cycle.

The bench runs directed cases for each of these, then long random mixes. It compares `in_ready`, `wb_conflict` and the completion stream against its own schedule on every cycle.

// File: rtl/fpi_pkg.sv
package fpi_pkg;
  localparam int OP_W      = 3;
  localparam int NUM_UNITS = 6;
  localparam int UNIT_W    = 3;
  localparam int MAX_LAT   = 112;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_MUL  = 3'd2,
    OP_DIV  = 3'd3,
    OP_SQRT = 3'd4,
    OP_NEG  = 3'd5,
    OP_ABS  = 3'd6,
    OP_CMP  = 3'd7
  } fp_op_e;

  // pipe index per opcode; add/sub share one pipe, negate/abs share one pipe
  function automatic logic [UNIT_W-1:0] op_to_unit(input logic [OP_W-1:0] op);
    case (fp_op_e'(op))
      OP_ADD, OP_SUB: return 3'd0;
      OP_MUL:         return 3'd1;
      OP_DIV:         return 3'd2;
      OP_SQRT:        return 3'd3;
      OP_NEG, OP_ABS: return 3'd4;
      default:        return 3'd5;
    endcase
  endfunction

  function automatic int unsigned unit_latency(input logic [UNIT_W-1:0] u);
    case (u)
      3'd0:    return 4;
      3'd1:    return 8;
      3'd2:    return 36;
      3'd3:    return 112;
      3'd4:    return 2;
      default: return 3;
    endcase
  endfunction

  function automatic int unsigned unit_interval(input logic [UNIT_W-1:0] u);
    case (u)
      3'd0:    return 3;
      3'd1:    return 4;
      3'd2:    return 35;
      3'd3:    return 111;
      3'd4:    return 1;
      default: return 2;
    endcase
  endfunction
endpackage

// File: rtl/fpi_unit_gate.sv
module fpi_unit_gate #(
  parameter int II    = 1,
  parameter int CNT_W = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  output logic free
);
  logic [CNT_W-1:0] wait_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              wait_q <= '0;
    else if (take)           wait_q <= CNT_W'(II - 1);
    else if (wait_q != '0)   wait_q <= wait_q - 1'b1;
  end

  assign free = (wait_q == '0);

  AST_INTERVAL_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (free == (II == 1))); // R3
  AST_BUSY_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !free |-> !take); // R3
endmodule

// File: rtl/fpi_slot.sv
module fpi_slot #(
  parameter int TAG_W = 6,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic [TAG_W-1:0] load_tag,
  output logic             active,
  output logic [CNT_W-1:0] remain,
  output logic [TAG_W-1:0] tag,
  output logic             fire
);
  assign fire = active && (remain == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      remain <= '0;
      tag    <= '0;
    end else if (fire) begin
      active <= 1'b0;
    end else if (load) begin
      active <= 1'b1;
      remain <= load_cnt;
      tag    <= load_tag;
    end else if (active) begin
      remain <= remain - 1'b1;
    end
  end

  AST_SLOT_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !active); // R2
  AST_LOAD_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !active); // R7
endmodule

// File: rtl/fpi_issue_ctrl.sv
module fpi_issue_ctrl
  import fpi_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int NSLOTS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OP_W-1:0]  in_op,
  input  logic [TAG_W-1:0] in_tag,
  output logic             done_valid,
  output logic [TAG_W-1:0] done_tag,
  output logic             wb_conflict
);
  localparam int CNT_W  = $clog2(MAX_LAT + 2);
  localparam int SLOT_W = (NSLOTS > 1) ? $clog2(NSLOTS) : 1;

  logic [UNIT_W-1:0]    sel_unit;
  logic [CNT_W-1:0]     new_lat;
  logic [NUM_UNITS-1:0] unit_free;
  logic [NUM_UNITS-1:0] unit_take;
  logic [NSLOTS-1:0]    slot_act, slot_fire, slot_load;
  logic [CNT_W-1:0]     slot_cnt [NSLOTS];
  logic [TAG_W-1:0]     slot_tag [NSLOTS];
  logic                 any_free, collide, accept;
  logic [SLOT_W-1:0]    free_idx;
  logic [TAG_W-1:0]     fire_tag;

  assign sel_unit = op_to_unit(in_op);
  assign new_lat  = CNT_W'(unit_latency(sel_unit));

  // per-pipe spacing gates
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    assign unit_take[u] = accept && (sel_unit == UNIT_W'(u));
    fpi_unit_gate #(
      .II   (int'(unit_interval(UNIT_W'(u)))),
      .CNT_W(CNT_W)
    ) u_gate (
      .clk  (clk),
      .rst_n(rst_n),
      .take (unit_take[u]),
      .free (unit_free[u])
    );
  end

  // lowest free in-flight entry
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = NSLOTS - 1; i >= 0; i--) begin
      if (!slot_act[i]) begin
        any_free = 1'b1;
        free_idx = SLOT_W'(i);
      end
    end
  end

  // a slot with remaining count L+1 retires on the same edge the new op would
  always_comb begin
    collide = 1'b0;
    for (int i = 0; i < NSLOTS; i++)
      if (slot_act[i] && slot_cnt[i] == new_lat + CNT_W'(1)) collide = 1'b1;
  end

  assign in_ready    = unit_free[sel_unit] && any_free && !collide;
  assign wb_conflict = in_valid && collide;
  assign accept      = in_valid && in_ready;

  for (genvar s = 0; s < NSLOTS; s++) begin : g_slot
    assign slot_load[s] = accept && (free_idx == SLOT_W'(s));
    fpi_slot #(
      .TAG_W(TAG_W),
      .CNT_W(CNT_W)
    ) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (slot_load[s]),
      .load_cnt(new_lat),
      .load_tag(in_tag),
      .active  (slot_act[s]),
      .remain  (slot_cnt[s]),
      .tag     (slot_tag[s]),
      .fire    (slot_fire[s])
    );
  end

  always_comb begin
    fire_tag = '0;
    for (int i = 0; i < NSLOTS; i++)
      if (slot_fire[i]) fire_tag = fire_tag | slot_tag[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_valid <= 1'b0;
      done_tag   <= '0;
    end else begin
      done_valid <= |slot_fire;
      done_tag   <= fire_tag;
    end
  end

  AST_SINGLE_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_fire)); // R8
  AST_CONFLICT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    wb_conflict |-> !in_ready); // R6
  AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (&slot_act) |-> !in_ready); // R7
endmodule

// File: tb/fpi_issue_ctrl_tb.sv
module fpi_issue_ctrl_tb;
  localparam int TAG_W = 6;
  localparam int NS    = 4;
  localparam int DIR_N = 14;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, done_valid, wb_conflict;
  logic [2:0] in_op;
  logic [TAG_W-1:0] in_tag, done_tag;

  always #4 clk = ~clk;  // 125 MHz

  fpi_issue_ctrl #(.TAG_W(TAG_W), .NSLOTS(NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_tag(in_tag), .done_valid(done_valid),
    .done_tag(done_tag), .wb_conflict(wb_conflict)
  );

  int checks = 0, errors = 0;
  int now = 0, seq = 0, accepts = 0, completions = 0;
  bit live [64];
  int mdone [64];
  int uok [6];
  bit finished = 0;

  function automatic int b_unit(input int op);
    case (op) 0, 1: return 0; 2: return 1; 3: return 2; 4: return 3; 5, 6: return 4; default: return 5; endcase
  endfunction
  function automatic int b_lat(input int op);
    case (op) 0, 1: return 4; 2: return 8; 3: return 36; 4: return 112; 5, 6: return 2; default: return 3; endcase
  endfunction
  function automatic int b_ii(input int op);
    case (op) 0, 1: return 3; 2: return 4; 3: return 35; 4: return 111; 5, 6: return 1; default: return 2; endcase
  endfunction
  // directed list: opcode and idle cycles before offering it
  function automatic int d_op(input int i);
    case (i) 0: return 4; 1: return 5; 2: return 2; 3: return 0; 4: return 0; 5: return 1;
      6: return 3; 7: return 5; 8: return 3; 9: return 4; 10: return 3; 11: return 2;
      12: return 0; default: return 7; endcase
  endfunction
  function automatic int d_gap(input int i);
    case (i) 2: return 120; 3: return 3; 4: return 20; 6: return 20; 9: return 120; default: return 0; endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic offer(input int op);
    in_valid = 1'b1;
    in_op    = 3'(op);
    in_tag   = TAG_W'(seq);
    seq++;
  endtask

  initial begin
    bit acc, hold, stop, r5_seen;
    int dir_i, gapc, rcount, drain;
    void'($urandom(32'h5EED1234));
    foreach (live[t]) begin live[t] = 0; mdone[t] = 0; end
    foreach (uok[u]) uok[u] = 0;
    acc = 0; stop = 0; r5_seen = 0; dir_i = 0; gapc = 0; rcount = 0; drain = 0;
    in_valid = 0; in_op = 0; in_tag = 0; rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    #1;
    chk(done_valid == 0, "R1 done_valid", done_valid, 0);
    chk(wb_conflict == 0, "R1 wb_conflict", wb_conflict, 0);
    for (int op = 0; op < 8; op++) begin
      in_op = 3'(op); #1;
      chk(in_ready == 1, "R1 in_ready", in_ready, 1);
    end
    in_op = 0;
    while (!stop) begin
      int nexp, etag, u, L, nlive;
      bit conf, uok_b, er;
      string rq;
      @(posedge clk);
      now++;
      if (acc) begin
        live[in_tag]  = 1;
        mdone[in_tag] = now + b_lat(in_op);
        uok[b_unit(in_op)] = now - 1 + b_ii(in_op);
        accepts++;
      end
      hold = in_valid && !acc;
      @(negedge clk);
      // completion side
      nexp = 0; etag = 0;
      for (int t = 0; t < 64; t++)
        if (live[t] && mdone[t] == now) begin nexp++; etag = t; live[t] = 0; end
      chk(nexp <= 1, "R8 model collision", nexp, 1);
      chk(done_valid == (nexp != 0), "R2 done_valid", done_valid, nexp != 0);
      if (nexp != 0) begin
        completions++;
        if (done_valid) chk(done_tag == TAG_W'(etag), "R2 done_tag", done_tag, etag);
        if (!r5_seen && etag == 1) begin
          r5_seen = 1;
          chk(live[0] == 1 && !done_valid == 0, "R5 negate before root", live[0], 1);
        end
      end
      // issue side stimulus (held while refused: R4)
      if (!hold) begin
        if (dir_i < DIR_N) begin
          if (gapc < d_gap(dir_i)) begin in_valid = 0; gapc++; end
          else begin offer(d_op(dir_i)); dir_i++; gapc = 0; end
        end else if (rcount < 2500) begin
          int r, k;
          rcount++;
          r = int'($urandom % 100);
          if (r < 30) in_valid = 0;
          else if (r < 32) offer(4);
          else if (r < 36) offer(3);
          else begin
            k = int'($urandom % 6);
            offer(k < 3 ? k : k + 2);
          end
        end else begin
          in_valid = 0;
          drain++;
          if (drain > 150) stop = 1;
        end
      end
      #1;
      u = b_unit(in_op); L = b_lat(in_op);
      uok_b = (now >= uok[u]);
      nlive = 0; conf = 0;
      for (int t = 0; t < 64; t++) begin
        if (live[t]) nlive++;
        if (live[t] && mdone[t] == now + 1 + L) conf = 1;
      end
      er = uok_b && (nlive < NS) && !conf;
      rq = conf ? "R6 in_ready" : (!uok_b ? "R3 in_ready" : (nlive >= NS ? "R7 in_ready" : "R9 in_ready"));
      if (in_valid) chk(in_ready == er, rq, in_ready, er);
      chk(wb_conflict == (in_valid && conf), "R6 wb_conflict", wb_conflict, in_valid && conf);
      acc = in_valid && er;
    end
    begin
      int left;
      left = 0;
      for (int t = 0; t < 64; t++) if (live[t]) left++;
      chk(completions == accepts, "R4 completions", completions, accepts);
      chk(left == 0, "R4 drained", left, 0);
      chk(r5_seen, "R5 observed", r5_seen, 1);
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R4 watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule